// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block turns single-word requests from a clocked on-chip port into the strobe sequences that an external asynchronous static RAM expects. The RAM has 19 address bits and an 8-bit bidirectional data bus. The controller drives a pair of chip selects of opposite polarity, an output enable and a read/write strobe. It also provides the output value and output enable for the data pads, so the tri-state buffer itself sits at the chip edge.

Each phase of an access lasts a whole number of clock cycles, and each count is a parameter. The phases are the read access, the write setup, the write pulse and the bus turnaround. Their counts are chosen by rounding the memory's nanosecond minimums up to clock periods. The controller takes one request at a time. Address and write data are latched when the request is accepted. Every access ends in a deselected turnaround phase, and only after that phase does the port accept new work.

Top module: `sram_ctrl`

## Requirements
- R1: Out of reset and whenever `req_ready` is high, the memory is deselected: `mem_sel_n`=1, `mem_sel`=0, `mem_oe_n`=1, `mem_rw`=1, and `pad_oe`=0.
- R2: The two chip selects always carry complementary values. The memory is selected only during the read access, write setup and write pulse phases.
- R3: A read holds `mem_oe_n` low and `mem_rw` high for exactly ACC_CYC consecutive cycles, with the memory selected throughout.
- R4: Read data is sampled on the last access cycle. `rsp_valid` is a single-cycle pulse in the cycle just after that, carrying the sampled byte on `rsp_data`. Writes never raise `rsp_valid`.
- R5: A write first spends exactly SETUP_CYC cycles selected, with `mem_rw` high and data driven. It then holds `mem_rw` low for exactly PULSE_CYC consecutive cycles.
- R6: Through the whole write, `mem_oe_n` stays high and `pad_oe` stays high. `pad_out` holds the accepted write byte.
- R7: `pad_oe` is never high while `mem_oe_n` is low.
- R8: Every access ends with exactly TURN_CYC deselected cycles before `req_ready` returns. A read is busy for ACC_CYC+TURN_CYC cycles; a write is busy for SETUP_CYC+PULSE_CYC+TURN_CYC cycles.
- R9: `req_ready` is low from the accepting edge until the turnaround finishes. A `req_valid` presented while `req_ready` is low is ignored and leaves the memory contents untouched.
- R10: `mem_addr` and `pad_out` come from values latched at acceptance. Changes on `req_addr` and `req_wdata` during an access have no effect on them.
- R11: A read issued right after a write to the same address returns the written byte, at any address including 0 and the top address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle pulse, read byte available |
| rsp_data | output | 8 | Read byte |
| mem_addr | output | 19 | Address to the memory |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_rw | output | 1 | Read/write strobe, low = write |
| pad_out | output | 8 | Value driven onto the data bus |
| pad_oe | output | 1 | Data bus driver enable |
| pad_in | input | 8 | Value sampled from the data bus |

## Verification
The hardest situations to reach from the ports arise while the controller is busy. One is a request arriving during an access; the other is the request inputs changing underneath a latched access. Both are invisible unless they corrupt the memory later. The bench covers them with a dedicated scenario. During every busy cycle it holds `req_valid` high with a different address and byte, and it scrambles `req_addr` and `req_wdata`. It drops `req_valid` in the same half cycle in which `req_ready` returns. A following read of the intruding address then shows whether anything leaked into the memory model.

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
  parameter int AW        = 19,
  parameter int DW        = 8,
  parameter int ACC_CYC   = 8,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 6,
  parameter int TURN_CYC  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_sel_n,
  output logic          mem_sel,
  output logic          mem_oe_n,
  output logic          mem_rw,
  output logic [DW-1:0] pad_out,
  output logic          pad_oe,
  input  logic [DW-1:0] pad_in
);
  localparam int ACC_N = (ACC_CYC   < 1) ? 1 : ACC_CYC;
  localparam int SU_N  = (SETUP_CYC < 1) ? 1 : SETUP_CYC;
  localparam int PL_N  = (PULSE_CYC < 1) ? 1 : PULSE_CYC;
  localparam int TN_N  = (TURN_CYC  < 1) ? 1 : TURN_CYC;
  localparam int M1    = (ACC_N > SU_N) ? ACC_N : SU_N;
  localparam int M2    = (PL_N > TN_N) ? PL_N : TN_N;
  localparam int MAXN  = (M1 > M2) ? M1 : M2;
  localparam int CW    = (MAXN < 2) ? 1 : $clog2(MAXN);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WSU, S_WPL, S_TURN} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] a_q;
  logic [DW-1:0] d_q;
  logic          sel;
  wire           last = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      a_q       <= '0;
      d_q       <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          a_q <= req_addr;
          d_q <= req_wdata;
          if (req_write) begin
            st  <= S_WSU;
            cnt <= CW'(SU_N - 1);
          end else begin
            st  <= S_RD;
            cnt <= CW'(ACC_N - 1);
          end
        end
        S_RD: if (last) begin
          rsp_data  <= pad_in;
          rsp_valid <= 1'b1;
          st        <= S_TURN;
          cnt       <= CW'(TN_N - 1);
        end else cnt <= cnt - 1'b1;
        S_WSU: if (last) begin
          st  <= S_WPL;
          cnt <= CW'(PL_N - 1);
        end else cnt <= cnt - 1'b1;
        S_WPL: if (last) begin
          st  <= S_TURN;
          cnt <= CW'(TN_N - 1);
        end else cnt <= cnt - 1'b1;
        S_TURN: if (last) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign sel       = (st == S_RD) || (st == S_WSU) || (st == S_WPL);
  assign req_ready = (st == S_IDLE);
  assign mem_sel   = sel;
  assign mem_sel_n = ~sel;
  assign mem_oe_n  = (st != S_RD);
  assign mem_rw    = (st != S_WPL);
  assign pad_oe    = (st == S_WSU) || (st == S_WPL);
  assign pad_out   = d_q;
  assign mem_addr  = a_q;
endmodule

module sram_ctrl_chk #(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_sel_n,
  input logic          mem_sel,
  input logic          mem_oe_n,
  input logic          mem_rw,
  input logic [DW-1:0] pad_out,
  input logic          pad_oe
);
  assert_idle_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_sel_n && !mem_sel && mem_oe_n && mem_rw && !pad_oe));
  assert_sel_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sel_n != mem_sel);
  assert_read_strobes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_rw && mem_sel));
  assert_rsp_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_write_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rw |-> (mem_sel && pad_oe && mem_oe_n));
  assert_wdata_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe && $past(pad_oe)) |-> $stable(pad_out));
  assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !pad_oe);
  assert_turn_after_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_sel) |-> !req_ready);
  assert_addr_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_sel && $past(mem_sel)) |-> $stable(mem_addr));
endmodule

bind sram_ctrl sram_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
  .mem_oe_n(mem_oe_n), .mem_rw(mem_rw), .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb;
  localparam int ACC = 8, SU = 2, PL = 6, TN = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid, mem_sel_n, mem_sel, mem_oe_n, mem_rw, pad_oe;
  logic [7:0]  rsp_data, pad_out, pad_in;
  logic [18:0] mem_addr;

  int checks = 0, errors = 0;
  logic [7:0] ram [int];
  logic [7:0] model [int];

  always #2.5 clk = ~clk;

  sram_ctrl #(.ACC_CYC(ACC), .SETUP_CYC(SU), .PULSE_CYC(PL), .TURN_CYC(TN)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_addr(mem_addr),
    .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_oe_n(mem_oe_n), .mem_rw(mem_rw),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in)
  );

  wire chip_on = !mem_sel_n && mem_sel;
  always_comb begin
    pad_in = 8'hzz;
    if (chip_on && !mem_oe_n && mem_rw)
      pad_in = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'h00;
  end
  always @(negedge clk) if (chip_on && !mem_rw && pad_oe) ram[int'(mem_addr)] = pad_out;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_op(input bit wr, input logic [18:0] a, input logic [7:0] d, input bit noisy);
    int n = 0, oe = 0, we = 0, su = 0, rsp = 0, rsp_at = 0, clash = 0, aerr = 0, derr = 0, half = 0;
    logic [7:0] got = 8'h00;
    logic [7:0] exp;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready before request", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready && n < 200) begin
      n++;
      if (mem_sel_n == mem_sel) half++;
      if (!mem_oe_n) oe++;
      if (!mem_rw) we++;
      if (chip_on && mem_rw && pad_oe) su++;
      if (rsp_valid) begin rsp++; rsp_at = n; got = rsp_data; end
      if (pad_oe && !mem_oe_n) clash++;
      if (chip_on && mem_addr != a) aerr++;
      if (pad_oe && pad_out != d) derr++;
      if (noisy) begin
        req_valid = 1'b1; req_write = 1'b1;
        req_addr = a ^ 19'h15555; req_wdata = ~d ^ 8'(n);
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(half == 0, "R2 selects complementary", half, 0);
    chk(clash == 0, "R7 no bus contention", clash, 0);
    chk(aerr == 0, "R10 address held", aerr, 0);
    if (wr) begin
      model[int'(a)] = d;
      chk(su == SU, "R5 setup cycles", su, SU);
      chk(we == PL, "R5 pulse cycles", we, PL);
      chk(oe == 0, "R6 oe high in write", oe, 0);
      chk(derr == 0, "R6 write data held", derr, 0);
      chk(rsp == 0, "R4 no rsp on write", rsp, 0);
      chk(n == SU + PL + TN, "R8 write busy cycles", n, SU + PL + TN);
    end else begin
      exp = model.exists(int'(a)) ? model[int'(a)] : 8'h00;
      chk(oe == ACC, "R3 access cycles", oe, ACC);
      chk(we == 0, "R3 rw high in read", we, 0);
      chk(rsp == 1, "R4 single pulse", rsp, 1);
      chk(rsp_at == ACC + 1, "R4 pulse timing", rsp_at, ACC + 1);
      chk(got == exp, "R11 read data", got, exp);
      chk(n == ACC + TN, "R8 read busy cycles", n, ACC + TN);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready && mem_sel_n && !mem_sel && mem_oe_n && mem_rw && !pad_oe && !rsp_valid,
        "R1 reset state", {req_ready, mem_sel_n, mem_sel, mem_oe_n, mem_rw, pad_oe, rsp_valid}, 7'b1101100);
  endtask

  task automatic t_patterns();
    do_op(1'b1, 19'h00000, 8'hA5, 1'b0);
    do_op(1'b0, 19'h00000, 8'h00, 1'b0);
    do_op(1'b1, 19'h7FFFF, 8'hFF, 1'b0);
    do_op(1'b0, 19'h7FFFF, 8'h00, 1'b0);
    do_op(1'b1, 19'h2A5C3, 8'h00, 1'b0);
    do_op(1'b0, 19'h2A5C3, 8'h00, 1'b0);
    do_op(1'b0, 19'h01234, 8'h00, 1'b0);
    t_reset();
  endtask

  task automatic t_busy_noise();
    do_op(1'b1, 19'h0F0F0, 8'h3C, 1'b1);
    do_op(1'b0, 19'h0F0F0, 8'h00, 1'b1);
    do_op(1'b0, 19'h0F0F0 ^ 19'h15555, 8'h00, 1'b0);
    chk(!ram.exists(int'(19'h0F0F0 ^ 19'h15555)), "R9 busy request ignored", 0, 0);
  endtask

  task automatic t_back_to_back();
    for (int i = 0; i < 4; i++) begin
      do_op(1'b1, 19'(i * 19'h11111), 8'(8'h81 + i * 8'h17), 1'b0);
      do_op(1'b0, 19'(i * 19'h11111), 8'h00, 1'b0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_patterns();
    t_busy_noise();
    t_back_to_back();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule